// File: doc/BRIEF.md
# Saturating Add-Compare-Select Array with Deferred Normalisation

This block is the metric core of a rate-1/2 trellis decoder with constraint length 7. It has one node for each trellis state, 64 by default. Each node holds a small metric, where a lower value means a more likely path. On every accepted set of branch metrics, each node adds a metric to each of its two predecessor metrics. It keeps the smaller sum and records which predecessor won in a one-bit local decision. Sums never wrap: they clip at a ceiling of 7.

The block does not search for the smallest metric with a comparator tree. Any node whose new metric is zero is taken as the best state. When no node reaches zero, the block reports that no best state exists for that step. It then takes one unit off every metric during the next update, and only during that one update. The decision vector, the best-state index and its qualifier feed a traceback stage elsewhere. An upstream unit supplies four branch metrics, one for each possible transmitted symbol pair.

Top module: `sacs_array`

## Requirements
- R1: Reset values:
  - State 0 holds metric 0 and every other state holds metric 7.
  - The decision vector, best-state index, best-state qualifier and result strobe all read 0.
  - No unit is pending to be taken off the metrics.
- R2: Trellis connections and branch-metric field:
  - State s has two predecessors: p0 = s>>1 and p1 = (s>>1)+32.
  - For the branch from p to s, form the 7-bit window w = 2*p + (s & 1).
  - Let a be the parity of w AND octal 171, and b be the parity of w AND octal 133.
  - That branch uses metric field number 2*a + b of `bm_i`, which occupies bits [f*3+2 : f*3].
- R3: The new metric of a state is the smaller of its two candidate sums. Its decision bit is 1 only when the p1 candidate is strictly smaller. A tie gives 0.
- R4: A candidate sum above 7 becomes 7. Such a sum is clipped, never wrapped.
- R5: When any new metric is 0, `gw_valid_o` goes to 1 and `gw_idx_o` gives the lowest-numbered state whose new metric is 0.
- R6: When no new metric is 0, `gw_valid_o` goes to 0 and `gw_idx_o` to 0. The next accepted update then forms each candidate from its predecessor metric minus 1 before the branch metric is added.
- R7: The deduction is exactly one unit and applies to one update only. It stays pending across idle cycles. It is repeated only if that later update again produces no zero metric.
- R8: A transfer with `bm_valid_i` high at a rising edge updates all outputs at that edge. `upd_o` is high for exactly the one cycle after that edge.
- R9: While `bm_valid_i` is low, the metrics, the decision vector, the best-state outputs and any pending deduction all stay unchanged, and `upd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_valid_i | input | 1 | A set of branch metrics is presented this cycle |
| bm_i | input | 12 | Four 3-bit branch metrics, field f at bits [3f+2:3f] |
| lw_o | output | 64 | Local decision bit for each state |
| gw_idx_o | output | 6 | Lowest state with a zero metric after the last update |
| gw_valid_o | output | 1 | A zero-metric state existed after the last update |
| upd_o | output | 1 | Result strobe, one cycle after each accepted update |

## Verification
Clipping and the one-unit deduction can act on the same add. A metric held at 7 loses one unit before its branch metric is added, and a clipped sum may still come back at 7.

The bench provokes this overlap in three ways:
- it drives every branch metric to 7 until all metrics sit at the ceiling and no best state exists;
- it then offers a single low-cost symbol, with idle cycles placed between the failing update and the deducting one;
- it runs a long pseudo-random phase in which both effects meet at many metric values.

Each decision vector and best-state result is judged against a per-state model of the arithmetic held in the bench.

// File: rtl/sacs_pkg.sv
package sacs_pkg;

  localparam int POLY_A = 'o171;
  localparam int POLY_B = 'o133;

  // Field number of the branch from predecessor pred to a state whose
  // newest input bit is bit_in, for a window of k bits.
  function automatic int branch_code(input int pred, input int bit_in, input int k);
    logic [31:0] win;
    logic        pa;
    logic        pb;
    win = 32'(((pred << 1) | bit_in) & ((1 << k) - 1));
    pa  = ^(win & 32'(POLY_A));
    pb  = ^(win & 32'(POLY_B));
    return (int'(pa) << 1) | int'(pb);
  endfunction

  // Candidate sum: optional one-unit deduction, then add, then clip.
  function automatic int acs_sum(input int sm, input int bm, input logic dec, input int cap);
    int base;
    base = (dec && sm != 0) ? sm - 1 : sm;
    base = base + bm;
    return (base > cap) ? cap : base;
  endfunction

endpackage

// File: rtl/sacs_node.sv
module sacs_node
  import sacs_pkg::*;
#(
  parameter int MW      = 3,
  parameter int BMW     = 3,
  parameter int CAP     = 7,
  parameter int RST_VAL = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           dec_i,
  input  logic [MW-1:0]  sm_lo_i,
  input  logic [MW-1:0]  sm_hi_i,
  input  logic [BMW-1:0] bm_lo_i,
  input  logic [BMW-1:0] bm_hi_i,
  output logic [MW-1:0]  sm_o,
  output logic           lw_o,
  output logic [MW-1:0]  nxt_o
);

  logic [MW-1:0] cand_lo;
  logic [MW-1:0] cand_hi;
  logic          pick_hi;

  always_comb begin
    cand_lo = MW'(acs_sum(int'(sm_lo_i), int'(bm_lo_i), dec_i, CAP));
    cand_hi = MW'(acs_sum(int'(sm_hi_i), int'(bm_hi_i), dec_i, CAP));
    pick_hi = (cand_hi < cand_lo);
    nxt_o   = pick_hi ? cand_hi : cand_lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sm_o <= MW'(RST_VAL);
      lw_o <= 1'b0;
    end else if (en_i) begin
      sm_o <= nxt_o;
      lw_o <= pick_hi;
    end
  end

  // R4: both predecessors at the ceiling and no deduction keep the node at the ceiling
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dec_i && sm_lo_i == MW'(CAP) && sm_hi_i == MW'(CAP)) |=> (sm_o == MW'(CAP)));

endmodule

// File: rtl/sacs_zero_pick.sv
module sacs_zero_pick #(
  parameter int NS = 64,
  parameter int MW = 3,
  parameter int IW = 6
) (
  input  logic [MW-1:0] met_i [NS],
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  logic [NS-1:0] is_zero;

  for (genvar s = 0; s < NS; s++) begin : g_flag
    assign is_zero[s] = (met_i[s] == '0);
  end

  always_comb begin
    any_o = |is_zero;
    idx_o = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (is_zero[s]) idx_o = IW'(s);
    end
  end

endmodule

// File: rtl/sacs_gw_reg.sv
module sacs_gw_reg #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          any_zero_i,
  input  logic [IW-1:0] idx_i,
  output logic          gw_valid_o,
  output logic [IW-1:0] gw_idx_o,
  output logic          dec_o,
  output logic          upd_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gw_valid_o <= 1'b0;
      gw_idx_o   <= '0;
      dec_o      <= 1'b0;
      upd_o      <= 1'b0;
    end else begin
      upd_o <= en_i;
      if (en_i) begin
        gw_valid_o <= any_zero_i;
        gw_idx_o   <= any_zero_i ? idx_i : '0;
        dec_o      <= !any_zero_i;
      end
    end
  end

  // R6: after an update, a result is either qualified or a deduction is pending
  p_gwv_vs_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (gw_valid_o != dec_o));

  // R7: a pending deduction survives idle cycles unchanged
  p_dec_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(dec_o));

endmodule

// File: rtl/sacs_array.sv
module sacs_array
  import sacs_pkg::*;
#(
  parameter int K   = 7,
  parameter int MW  = 3,
  parameter int BMW = 3,
  parameter int CAP = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bm_valid_i,
  input  logic [4*BMW-1:0]              bm_i,
  output logic [(1 << (K - 1)) - 1:0]   lw_o,
  output logic [K-2:0]                  gw_idx_o,
  output logic                          gw_valid_o,
  output logic                          upd_o
);

  localparam int NS   = 1 << (K - 1);
  localparam int IW   = K - 1;
  localparam int HALF = NS / 2;

  logic [MW-1:0] sm_q  [NS];
  logic [MW-1:0] sm_nx [NS];
  logic          dec_pend;
  logic          any_zero;
  logic [IW-1:0] zero_idx;
  logic          cur_any_zero;

  for (genvar s = 0; s < NS; s++) begin : g_node
    localparam int PLO = s >> 1;
    localparam int PHI = PLO + HALF;
    localparam int CLO = branch_code(PLO, s % 2, K);
    localparam int CHI = branch_code(PHI, s % 2, K);

    sacs_node #(
      .MW      (MW),
      .BMW     (BMW),
      .CAP     (CAP),
      .RST_VAL ((s == 0) ? 0 : CAP)
    ) u_node (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (bm_valid_i),
      .dec_i   (dec_pend),
      .sm_lo_i (sm_q[PLO]),
      .sm_hi_i (sm_q[PHI]),
      .bm_lo_i (bm_i[CLO*BMW +: BMW]),
      .bm_hi_i (bm_i[CHI*BMW +: BMW]),
      .sm_o    (sm_q[s]),
      .lw_o    (lw_o[s]),
      .nxt_o   (sm_nx[s])
    );
  end

  sacs_zero_pick #(
    .NS (NS),
    .MW (MW),
    .IW (IW)
  ) u_pick (
    .met_i (sm_nx),
    .any_o (any_zero),
    .idx_o (zero_idx)
  );

  sacs_gw_reg #(
    .IW (IW)
  ) u_gw (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (bm_valid_i),
    .any_zero_i (any_zero),
    .idx_i      (zero_idx),
    .gw_valid_o (gw_valid_o),
    .gw_idx_o   (gw_idx_o),
    .dec_o      (dec_pend),
    .upd_o      (upd_o)
  );

  always_comb begin
    cur_any_zero = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (sm_q[s] == '0) cur_any_zero = 1'b1;
    end
  end

  // R5: the reported best state really holds a zero metric
  p_gw_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gw_valid_o |-> (sm_q[gw_idx_o] == '0));

  // R6: a deduction is only pending while every metric is at least 1
  p_dec_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pend |-> !cur_any_zero);

  // R9: idle cycles leave the outputs unchanged and the strobe low
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_valid_i |=> ($stable(lw_o) && $stable(gw_idx_o) && $stable(gw_valid_o) && !upd_o));

endmodule

// File: tb/sacs_array_tb.sv
module sacs_array_tb;

  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bm_valid_i = 1'b0;
  logic [11:0] bm_i = '0;
  logic [63:0] lw_o;
  logic [5:0]  gw_idx_o;
  logic        gw_valid_o;
  logic        upd_o;

  int checks = 0;
  int failures = 0;

  int          ref_sm [NS];
  bit          ref_dec;
  logic [63:0] exp_lw;
  int          exp_idx;
  bit          exp_gwv;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  sacs_array u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bm_valid_i (bm_valid_i),
    .bm_i       (bm_i),
    .lw_o       (lw_o),
    .gw_idx_o   (gw_idx_o),
    .gw_valid_o (gw_valid_o),
    .upd_o      (upd_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int fld(input int p, input int u);
    int w;
    int a;
    int b;
    w = (p * 2 + u) % 128;
    a = $countones(w & 'o171) % 2;
    b = $countones(w & 'o133) % 2;
    return a * 2 + b;
  endfunction

  function automatic void lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  // Reference step of the trellis, following R2..R7
  task automatic model(input int bm [4]);
    int nw [NS];
    bit found;
    found = 0;
    exp_idx = 0;
    for (int s = 0; s < NS; s++) begin
      int c [2];
      for (int j = 0; j < 2; j++) begin
        int p;
        int base;
        p = (s / 2) + 32 * j;
        base = ref_sm[p];
        if (ref_dec && base > 0) base = base - 1;
        c[j] = base + bm[fld(p, s % 2)];
        if (c[j] > 7) c[j] = 7;
      end
      exp_lw[s] = (c[1] < c[0]);
      nw[s] = exp_lw[s] ? c[1] : c[0];
      if (nw[s] == 0 && !found) begin
        found = 1;
        exp_idx = s;
      end
    end
    for (int s = 0; s < NS; s++) ref_sm[s] = nw[s];
    exp_gwv = found;
    ref_dec = !found;
  endtask

  task automatic update(input int b0, input int b1, input int b2, input int b3, input string tag);
    int bm [4];
    bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
    @(negedge clk);
    bm_i = {3'(b3), 3'(b2), 3'(b1), 3'(b0)};
    bm_valid_i = 1'b1;
    @(negedge clk);
    bm_valid_i = 1'b0;
    model(bm);
    chk(upd_o == 1'b1, {tag, " R8"}, "strobe", upd_o, 1);
    chk(lw_o == exp_lw, {tag, " R3"}, "decisions", lw_o, exp_lw);
    chk(gw_valid_o == exp_gwv, {tag, " R5 R6"}, "qualifier", gw_valid_o, exp_gwv);
    chk(int'(gw_idx_o) == exp_idx, {tag, " R5"}, "index", gw_idx_o, exp_idx);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk(upd_o == 1'b0, "R9", "idle strobe", upd_o, 0);
      chk(lw_o == exp_lw, "R9", "idle decisions", lw_o, exp_lw);
      chk(gw_valid_o == exp_gwv && int'(gw_idx_o) == exp_idx, "R9", "idle best state",
          {gw_valid_o, gw_idx_o}, {exp_gwv, 6'(exp_idx)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) ref_sm[s] = (s == 0) ? 0 : 7;
    ref_dec = 0;
    exp_lw = '0;
    exp_idx = 0;
    exp_gwv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of all outputs
    chk(lw_o == '0, "R1", "reset decisions", lw_o, 0);
    chk(gw_valid_o == 1'b0 && gw_idx_o == '0, "R1", "reset best state", {gw_valid_o, gw_idx_o}, 0);
    chk(upd_o == 1'b0, "R1", "reset strobe", upd_o, 0);

    // R1 R2: metrics from reset seen through a clean symbol stream
    update(0, 5, 5, 5, "R1 R2");
    update(0, 0, 0, 0, "R1 R2");
    update(6, 0, 3, 1, "R2");

    // R2 R3: light noise, many ties
    for (int i = 0; i < 40; i++) begin
      lf_step();
      update(int'(lf[1:0]) % 3, int'(lf[3:2]) % 3, int'(lf[5:4]) % 3, int'(lf[7:6]) % 3, "R2 R3");
    end
    for (int i = 0; i < 8; i++) update(1, 1, 1, 1, "R3 tie");

    // R4 R6: every branch costly, all metrics pinned at the ceiling
    for (int i = 0; i < 30; i++) update(7, 7, 7, 7, "R4 R6");

    // R6 R7: deduction held over idle gaps, then applied once
    for (int i = 0; i < 12; i++) begin
      idle(i % 4);
      update((i % 4 == 0) ? 0 : 7, (i % 4 == 1) ? 0 : 7, (i % 4 == 2) ? 1 : 7, 6, "R6 R7");
    end
    for (int i = 0; i < 10; i++) update(2, 3, 2, 3, "R6 R7");

    // R5 R8 R9: full-range random metrics with random gaps
    for (int i = 0; i < 250; i++) begin
      lf_step();
      if (lf[15:14] == 2'b00) idle(int'(lf[13:12]) + 1);
      update(int'(lf[2:0]), int'(lf[5:3]), int'(lf[8:6]), int'(lf[11:9]), "R4 R5 R7");
    end
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule